// File: doc/BRIEF.md
# SDRAM Command Decoder with Burst Termination

This block sits on the device side of a single-data-rate SDRAM command bus. On every rising clock edge it samples the three active-low strobes (row strobe, column strobe, write enable), the bank select and the address bus. Chip select is taken as always asserted. From these it decodes one command per cycle.

It keeps an open or closed flag and the latched row for every bank. It also runs one burst engine, which emits one beat per cycle. A write beat shows up as a write strobe, and a read beat shows up as a read-valid flag. Each beat carries its bank and its column, and the column wraps inside the block aligned to the burst length.

A running burst can end early in three ways, and each leaves a different final state:
- **A new read or write** restarts the engine at the new column.
- **A burst stop** halts the engine and keeps every bank open. Write data on the cycles after the stop is dropped.
- **A precharge** halts the engine and closes the addressed bank or all banks.

All outputs are registered. A beat or error caused by the command sampled at edge k is visible from edge k until edge k+1. The reset is asynchronous and active low, and it is expected to be deasserted synchronously to the clock by the surrounding logic.

Top module: `sdcmd_burst_tracker`

## Requirements
- R1: Commands are decoded from {ras_n,cas_n,we_n} as follows:
  - 011 is activate.
  - 101 is read.
  - 100 is write.
  - 010 is precharge.
  - 110 is burst stop.
  - 111, 000 and 001 are no-ops that change no bank flag, row or burst state and raise no error.
- R2: An activate sets bank_open[bank_sel] and latches addr into that bank's slice bank_row[b*ROW_W +: ROW_W], visible after the edge.
- R3: A precharge with addr[AP_BIT] high clears every bank_open bit whatever bank_sel holds. With addr[AP_BIT] low it clears only bit bank_sel, where 00=bank 0, 01=bank 1, 10=bank 2 and 11=bank 3.
- R4: A read or write to an open bank issues BURST_LEN beats on consecutive cycles, the first in the cycle after the command.
  - Beat i carries column (c & ~(BURST_LEN-1)) | ((c+i) mod BURST_LEN), where c = addr[COL_W-1:0].
  - The beat's bank is on beat_bank.
  - wr_strobe marks write beats and rd_valid marks read beats. The two are never high together.
- R5: A burst stop produces no beat in the following cycle and ends the burst. Later write beats of that burst are never strobed. All bank flags are unchanged, so a read to the same bank works with no new activate.
- R6: Any precharge ends the running burst, with no beat after it, in addition to closing banks per R3.
- R7: A read or write to an open bank during a burst replaces the old burst. The next beat is beat 0 of the new command, in its own direction, and the new burst runs its full length.
- R8: A read or write to a closed bank raises cmd_err for exactly the following cycle and issues no beat. A burst already running carries on as if the command were a no-op.
- R9: After reset all banks are closed, all rows are zero, no beat is issued and cmd_err is low.
- R10: An activate or a no-op during a burst does not disturb the burst's beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | BA_W | Bank address |
| addr | input | ROW_W | Row address on activate, column on read/write, all-bank flag at bit AP_BIT on precharge |
| bank_open | output | 2**BA_W | Per-bank open flag |
| bank_row | output | 2**BA_W*ROW_W | Latched row of each bank |
| wr_strobe | output | 1 | Accepted write beat |
| rd_valid | output | 1 | Read beat valid |
| beat_col | output | COL_W | Column of the current beat |
| beat_bank | output | BA_W | Bank of the current beat |
| cmd_err | output | 1 | Read or write to a closed bank |

## Verification
The column sequence is swept over both directions, all four banks and sixteen start columns. This covers every offset inside the wrap block and separates correct wrapping from plain increment or a missing beat.

Burst stop is tried at every possible beat position in both directions, which shows whether the cut drops exactly the remaining beats and leaves the bank open. Precharge during a burst, an interrupting read after a write, and a closed-bank access mid-burst tell apart the three termination outcomes and the ignore path. Single-bank and all-bank precharge, and the three no-op encodings, confirm that bank flags change only as addressed.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_BST
  } cmd_e;

  function automatic cmd_e decode_pins(input logic ras_n, input logic cas_n,
                                       input logic we_n);
    cmd_e c;
    case ({ras_n, cas_n, we_n})
      3'b011:  c = CMD_ACT;
      3'b101:  c = CMD_RD;
      3'b100:  c = CMD_WR;
      3'b010:  c = CMD_PRE;
      3'b110:  c = CMD_BST;
      default: c = CMD_NOP;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = decode_pins(ras_n, cas_n, we_n);
  end

endmodule

// File: rtl/sdcmd_bank_table.sv
module sdcmd_bank_table
  import sdcmd_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int AP_BIT = 10,
  localparam int NB    = 1 << BA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [BA_W-1:0]   ba,
  input  logic [ROW_W-1:0]  addr,
  output logic [NB-1:0]     open_q,
  output logic [NB*ROW_W-1:0] rows_q
);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    logic open_d;
    logic row_en;

    always_comb begin
      hit    = (ba == BA_W'(b));
      open_d = open_q[b];
      row_en = 1'b0;
      if (cmd == CMD_ACT && hit) begin
        open_d = 1'b1;
        row_en = 1'b1;
      end else if (cmd == CMD_PRE && (addr[AP_BIT] || hit)) begin
        open_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
      end else begin
        open_q[b] <= open_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rows_q[b*ROW_W +: ROW_W] <= '0;
      end else if (row_en) begin
        rows_q[b*ROW_W +: ROW_W] <= addr;
      end
    end
  end

endmodule

// File: rtl/sdcmd_burst_engine.sv
module sdcmd_burst_engine
  import sdcmd_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int COL_W     = 9,
  parameter int BURST_LEN = 4,
  localparam int LB       = $clog2(BURST_LEN),
  localparam int CW       = (LB > 0) ? LB : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  ba,
  input  logic [COL_W-1:0] col_in,
  input  logic             bank_ok,
  output logic             beat_vld_q,
  output logic             beat_wr_q,
  output logic [COL_W-1:0] beat_col_q,
  output logic [BA_W-1:0]  beat_bank_q,
  output logic             err_q
);

  // Burst state
  logic             act_q,  act_d;
  logic             dir_q,  dir_d;
  logic [BA_W-1:0]  bnk_q,  bnk_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [CW-1:0]    cnt_q,  cnt_d;
  logic             st_en;

  // Beat output next values
  logic             vld_d, bwr_d, err_d;
  logic [COL_W-1:0] bcol_d;
  logic [BA_W-1:0]  bbank_d;

  logic [COL_W-1:0] wrap_col;
  logic             last_beat;
  logic             is_rw;
  logic             cont;

  if (LB == 0) begin : g_bl1
    assign wrap_col = base_q;
  end else begin : g_blx
    logic [LB-1:0] low;
    assign low      = base_q[LB-1:0] + cnt_q[LB-1:0];
    assign wrap_col = {base_q[COL_W-1:LB], low};
  end

  assign last_beat = (cnt_q == CW'(BURST_LEN - 1));
  assign is_rw     = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_comb begin
    act_d   = act_q;
    dir_d   = dir_q;
    bnk_d   = bnk_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    st_en   = 1'b0;
    vld_d   = 1'b0;
    bwr_d   = 1'b0;
    bcol_d  = beat_col_q;
    bbank_d = beat_bank_q;
    err_d   = 1'b0;
    cont    = 1'b0;

    if (is_rw && bank_ok) begin
      st_en   = 1'b1;
      act_d   = (BURST_LEN > 1);
      dir_d   = (cmd == CMD_WR);
      bnk_d   = ba;
      base_d  = col_in;
      cnt_d   = CW'(1);
      vld_d   = 1'b1;
      bwr_d   = (cmd == CMD_WR);
      bcol_d  = col_in;
      bbank_d = ba;
    end else if (cmd == CMD_PRE || cmd == CMD_BST) begin
      st_en = act_q;
      act_d = 1'b0;
    end else begin
      err_d = is_rw;
      cont  = act_q;
    end

    if (cont) begin
      st_en   = 1'b1;
      vld_d   = 1'b1;
      bwr_d   = dir_q;
      bcol_d  = wrap_col;
      bbank_d = bnk_q;
      cnt_d   = cnt_q + CW'(1);
      act_d   = !last_beat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      dir_q  <= 1'b0;
      bnk_q  <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (st_en) begin
      act_q  <= act_d;
      dir_q  <= dir_d;
      bnk_q  <= bnk_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_vld_q  <= 1'b0;
      beat_wr_q   <= 1'b0;
      beat_col_q  <= '0;
      beat_bank_q <= '0;
      err_q       <= 1'b0;
    end else begin
      beat_vld_q  <= vld_d;
      beat_wr_q   <= bwr_d;
      beat_col_q  <= bcol_d;
      beat_bank_q <= bbank_d;
      err_q       <= err_d;
    end
  end

endmodule

// File: rtl/sdcmd_burst_tracker.sv
module sdcmd_burst_tracker
  import sdcmd_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4,
  localparam int NB       = 1 << BA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [BA_W-1:0]     bank_sel,
  input  logic [ROW_W-1:0]    addr,
  output logic [NB-1:0]       bank_open,
  output logic [NB*ROW_W-1:0] bank_row,
  output logic                wr_strobe,
  output logic                rd_valid,
  output logic [COL_W-1:0]    beat_col,
  output logic [BA_W-1:0]     beat_bank,
  output logic                cmd_err
);

  cmd_e cmd;
  logic beat_vld;
  logic beat_wr;
  logic bank_ok;

  sdcmd_decode u_decode (
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  sdcmd_bank_table #(
    .BA_W   (BA_W),
    .ROW_W  (ROW_W),
    .AP_BIT (AP_BIT)
  ) u_banks (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .ba     (bank_sel),
    .addr   (addr),
    .open_q (bank_open),
    .rows_q (bank_row)
  );

  assign bank_ok = bank_open[bank_sel];

  sdcmd_burst_engine #(
    .BA_W      (BA_W),
    .COL_W     (COL_W),
    .BURST_LEN (BURST_LEN)
  ) u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .ba          (bank_sel),
    .col_in      (addr[COL_W-1:0]),
    .bank_ok     (bank_ok),
    .beat_vld_q  (beat_vld),
    .beat_wr_q   (beat_wr),
    .beat_col_q  (beat_col),
    .beat_bank_q (beat_bank),
    .err_q       (cmd_err)
  );

  assign wr_strobe = beat_vld && beat_wr;
  assign rd_valid  = beat_vld && !beat_wr;

endmodule

// File: rtl/sdcmd_burst_tracker_chk.sv
module sdcmd_burst_tracker_chk #(
  parameter int BA_W = 2,
  localparam int NB  = 1 << BA_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] bank_sel,
  input logic            ap_flag,
  input logic [NB-1:0]   bank_open,
  input logic            wr_strobe,
  input logic            rd_valid,
  input logic            cmd_err
);

  logic pin_act, pin_rw, pin_pre, pin_bst;
  assign pin_act = ({ras_n, cas_n, we_n} == 3'b011);
  assign pin_rw  = ({ras_n, cas_n} == 2'b10);
  assign pin_pre = ({ras_n, cas_n, we_n} == 3'b010);
  assign pin_bst = ({ras_n, cas_n, we_n} == 3'b110);

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_act |=> bank_open[$past(bank_sel)]);

  p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pre && ap_flag) |=> (bank_open == '0));

  p_pre_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pre && !ap_flag) |=> !bank_open[$past(bank_sel)]);

  p_dir_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_strobe && rd_valid));

  p_bst_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_bst |=> (!wr_strobe && !rd_valid && $stable(bank_open)));

  p_pre_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pre |=> (!wr_strobe && !rd_valid));

  p_closed_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rw && !bank_open[bank_sel]) |=> cmd_err);

endmodule

bind sdcmd_burst_tracker sdcmd_burst_tracker_chk #(.BA_W(BA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .bank_sel  (bank_sel),
  .ap_flag   (addr[AP_BIT]),
  .bank_open (bank_open),
  .wr_strobe (wr_strobe),
  .rd_valid  (rd_valid),
  .cmd_err   (cmd_err)
);

// File: tb/sdcmd_burst_tracker_tb.sv
`timescale 1ns/1ps
module sdcmd_burst_tracker_tb;

  localparam int BA_W = 2;
  localparam int ROW_W = 13;
  localparam int COL_W = 9;
  localparam int AP_BIT = 10;
  localparam int BL = 4;
  localparam int NB = 4;

  logic clk, rst_n, ras_n, cas_n, we_n;
  logic [BA_W-1:0] bank_sel;
  logic [ROW_W-1:0] addr;
  logic [NB-1:0] bank_open;
  logic [NB*ROW_W-1:0] bank_row;
  logic wr_strobe, rd_valid, cmd_err;
  logic [COL_W-1:0] beat_col;
  logic [BA_W-1:0] beat_bank;

  int n_chk = 0;
  int n_err = 0;

  sdcmd_burst_tracker #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .BURST_LEN(BL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bank_sel(bank_sel), .addr(addr), .bank_open(bank_open), .bank_row(bank_row),
    .wr_strobe(wr_strobe), .rd_valid(rd_valid), .beat_col(beat_col),
    .beat_bank(beat_bank), .cmd_err(cmd_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int wcol(int c, int i);
    return (c & ~(BL - 1)) | ((c + i) % BL);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected beat: v=valid, w=write
  task automatic chk_beat(string req, bit v, bit w, int col, int bk);
    int a, e;
    a = {wr_strobe, rd_valid, 16'(v ? beat_col : 0), 4'(v ? beat_bank : 0)};
    e = {(v && w), (v && !w), 16'(v ? col : 0), 4'(v ? bk : 0)};
    chk(req, a, e);
  endtask

  task automatic issue(logic [2:0] pins, int bk, int ad);
    {ras_n, cas_n, we_n} = pins;
    bank_sel = BA_W'(bk);
    addr = ROW_W'(ad);
    @(posedge clk);
    @(negedge clk);
    {ras_n, cas_n, we_n} = 3'b111;
  endtask

  task automatic nop();   issue(3'b111, 0, 0); endtask
  task automatic bst();   issue(3'b110, 0, 0); endtask
  task automatic act(int bk, int row); issue(3'b011, bk, row); endtask
  task automatic rw(bit w, int bk, int col); issue(w ? 3'b100 : 3'b101, bk, col); endtask
  task automatic pre(int bk, bit all); issue(3'b010, bk, all ? (1 << AP_BIT) : 0); endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {ras_n, cas_n, we_n} = 3'b111;
    bank_sel = '0;
    addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 open", int'(bank_open), 0);
    chk("R9 rows", int'(bank_row == '0), 1);
    chk_beat("R9 beat", 0, 0, 0, 0);
    chk("R9 err", int'(cmd_err), 0);
    rst_n = 1'b1;
    nop();
    chk("R9 idle open", int'(bank_open), 0);

    // R2 activate every bank
    for (int b = 0; b < NB; b++) begin
      act(b, b * 100 + 7);
      chk("R2 open", int'(bank_open[b]), 1);
      chk("R2 row", int'(bank_row[b*ROW_W +: ROW_W]), b * 100 + 7);
    end

    // R4 full burst sweep
    for (int w = 0; w < 2; w++)
      for (int b = 0; b < NB; b++)
        for (int c = 0; c < 16; c++) begin
          rw(w[0], b, 'h40 + c);
          chk_beat("R4 beat0", 1, w[0], wcol('h40 + c, 0), b);
          for (int i = 1; i < BL; i++) begin
            nop();
            chk_beat("R4 beat", 1, w[0], wcol('h40 + c, i), b);
          end
          nop();
          chk_beat("R4 end", 0, 0, 0, 0);
        end

    // R5 burst stop at each position
    for (int w = 0; w < 2; w++)
      for (int j = 1; j < BL; j++) begin
        rw(w[0], 1, 5);
        chk_beat("R5 pre-stop beat0", 1, w[0], wcol(5, 0), 1);
        for (int i = 1; i < j; i++) begin
          nop();
          chk_beat("R5 pre-stop beat", 1, w[0], wcol(5, i), 1);
        end
        bst();
        chk_beat("R5 stop drop", 0, 0, 0, 0);
        chk("R5 banks open", int'(bank_open), 'hF);
        nop();
        chk_beat("R5 after stop", 0, 0, 0, 0);
      end
    rw(1'b0, 1, 9);
    chk_beat("R5 read same bank no act", 1, 0, 9, 1);
    chk("R5 no err", int'(cmd_err), 0);
    repeat (BL) nop();

    // R6 precharge mid-burst
    rw(1'b0, 2, 12);
    chk_beat("R6 beat0", 1, 0, 12, 2);
    pre(2, 0);
    chk_beat("R6 burst cut", 0, 0, 0, 0);
    chk("R6 closed", int'(bank_open), 'hB);
    nop();
    chk_beat("R6 stays quiet", 0, 0, 0, 0);

    // R8 closed bank access while idle
    rw(1'b1, 2, 3);
    chk("R8 err", int'(cmd_err), 1);
    chk_beat("R8 no beat", 0, 0, 0, 0);
    nop();
    chk("R8 err one cycle", int'(cmd_err), 0);

    // R8 closed bank access during a burst
    rw(1'b0, 0, 8);
    chk_beat("R8 b0", 1, 0, 8, 0);
    nop();
    chk_beat("R8 b1", 1, 0, 9, 0);
    rw(1'b0, 2, 0);
    chk("R8 err mid", int'(cmd_err), 1);
    chk_beat("R8 burst continues", 1, 0, 10, 0);
    nop();
    chk_beat("R8 last", 1, 0, 11, 0);
    nop();
    chk_beat("R8 end", 0, 0, 0, 0);

    // R7 interrupt write with read
    rw(1'b1, 0, 3);
    chk_beat("R7 wr beat0", 1, 1, 3, 0);
    nop();
    chk_beat("R7 wr beat1", 1, 1, wcol(3, 1), 0);
    rw(1'b0, 1, 10);
    chk_beat("R7 new beat0", 1, 0, 10, 1);
    for (int i = 1; i < BL; i++) begin
      nop();
      chk_beat("R7 new beat", 1, 0, wcol(10, i), 1);
    end
    nop();
    chk_beat("R7 end", 0, 0, 0, 0);

    // R10 activate and no-op during burst
    rw(1'b1, 3, 6);
    chk_beat("R10 b0", 1, 1, 6, 3);
    act(2, 55);
    chk_beat("R10 act keeps burst", 1, 1, wcol(6, 1), 3);
    chk("R10 act opened", int'(bank_open), 'hF);
    issue(3'b000, 0, 0);
    chk_beat("R10 nop keeps burst", 1, 1, wcol(6, 2), 3);
    nop();
    chk_beat("R10 b3", 1, 1, wcol(6, 3), 3);
    nop();

    // R1 no-op encodings change nothing
    for (int p = 0; p < 3; p++) begin
      issue(p == 0 ? 3'b000 : (p == 1 ? 3'b001 : 3'b111), 1, 1 << AP_BIT);
      chk("R1 no-op banks", int'(bank_open), 'hF);
      chk("R1 no-op err", int'(cmd_err), 0);
      chk_beat("R1 no-op beat", 0, 0, 0, 0);
    end
    chk("R1 row kept", int'(bank_row[2*ROW_W +: ROW_W]), 55);

    // R3 single and all-bank precharge
    for (int b = 0; b < NB; b++) begin
      pre(b, 0);
      chk("R3 single", int'(bank_open), 'hF & ~(1 << b));
      act(b, b);
    end
    pre(1, 1);
    chk("R3 all", int'(bank_open), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule